// File: doc/BRIEF.md
# Video DRAM Slot Arbiter

This block shares a single DRAM between processor accesses and display fetches. It uses a fixed interleave of one CPU cycle (one period of the 8 MHz base tick) per slot, and CPU slots alternate with display slots. The arbiter registers run on a 16 MHz clock. A one-clock `tick_8m` pulse on every second clock edge marks where each CPU cycle begins. Cycles are numbered from 0, starting at the first tick after reset.

Each display slot becomes either a one-word video fetch or a refresh request. The choice depends on the level of display-enable, sampled some time before the CPU slot that precedes the display slot. Display-enable therefore works as a level enable and not as an edge trigger. One cycle after each fetch, a one-clock load strobe goes to the pixel serializer.

A two-bit power-up phase input models the alignment that is left undetermined at power-up. Bit 0 sets which parity of cycle belongs to the CPU. Bit 1 sets how old the display-enable sample is. Together they give a first-load latency of 3, 4, 5 or 6 CPU cycles. The number of words fetched per line does not change with the phase.

Top module: `vdram_slot_arbiter`

## Requirements
- R1: While `rst_n` is low, and after release until the first tick, `cpu_grant`, `vid_grant`, `ref_req`, `load_stb` and `addr_step` are all zero.
- R2: Cycle n is a CPU slot when bit 0 of n differs from `wake_phase[0]`, and a display slot otherwise. In a CPU slot, `cpu_grant` is high exactly when `cpu_req` was high at the tick that starts the slot. A request made at the start of a display slot is ignored and gives no grant.
- R3: Let c be the CPU slot just before a display slot. That display slot is a video fetch when `de` was high at tick c-1 (`wake_phase[1]`=0) or tick c-3 (`wake_phase[1]`=1). Otherwise it raises `ref_req`. The level of `de` at other ticks has no effect on that slot.
- R4: A fetch holds `vid_grant` high for its whole slot, with `addr_step` = 2 (one 16-bit word). Outside a fetch, `addr_step` is 0. Grants and `ref_req` change only at tick edges.
- R5: `load_stb` is high for exactly one clock: the first clock of the cycle after each fetch.
- R6: When `de` rises at an even cycle e, the first `load_stb` of the line comes in cycle e+3+`wake_phase`.
- R7: When `de` is high from even cycle e to even cycle f (exclusive), the line gives (f-e)/2 loads for every phase, and the last load comes in cycle f+1+`wake_phase`.
- R8: At most one of `cpu_grant`, `vid_grant` and `ref_req` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 16 MHz arbiter clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_8m | input | 1 | One-clock pulse that starts each CPU cycle |
| de | input | 1 | Display-enable level from the timing generator |
| wake_phase | input | 2 | Power-up alignment, held constant after reset |
| cpu_req | input | 1 | Processor memory request |
| cpu_grant | output | 1 | DRAM slot granted to the processor |
| vid_grant | output | 1 | Display slot used for a video fetch |
| ref_req | output | 1 | Display slot used for refresh |
| addr_step | output | 4 | Byte increment for the video address counter |
| load_stb | output | 1 | Load strobe to the pixel serializer |

## Verification
The power-up alignment cannot be reached from a running block, because it only comes into play across a reset. For this reason each stimulus vector applies a reset with its own `wake_phase` value. It then raises `de` at an even cycle, so each of the four latencies shows as a distinct first-load cycle. One directed case raises `de` only at an odd tick. That sample never falls on a decision point, so no fetch may follow. Another directed case places processor requests only in display slots.

// File: rtl/vdram_arb_pkg.sv
// Shared types for the video DRAM slot arbiter.
package vdram_arb_pkg;
    // Kind of DRAM slot occupied by one CPU cycle.
    typedef enum logic {
        SLOT_CPU  = 1'b0,
        SLOT_DISP = 1'b1
    } slot_kind_e;
endpackage

// File: rtl/slot_phase_gen.sv
// Tracks the parity of the current CPU cycle and reports the kind of slot
// that the next tick begins. Assumes tick arrives on every second clock and
// that wake_sel is constant after reset. The first tick starts cycle 0.
module slot_phase_gen
    import vdram_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       wake_sel,
    output slot_kind_e next_kind
);
    logic par_q;   // parity of the cycle now running

    // Toggle parity at each cycle start; reset to 1 so cycle 0 is even.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q <= 1'b1;
        end else if (tick) begin
            par_q <= ~par_q;
        end
    end

    // Display slots sit on the parity picked by the wake-up selector.
    always_comb begin
        next_kind = ((~par_q) == wake_sel) ? SLOT_DISP : SLOT_CPU;
    end
endmodule

// File: rtl/de_sampler.sv
// Samples display-enable once per CPU cycle into a short history. It returns
// the sample that is BASE_DLY or BASE_DLY+2 cycles old, picked by deep_sel.
// Assumes de is stable around each tick edge.
module de_sampler #(
    parameter int BASE_DLY = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic de,
    input  logic deep_sel,
    output logic de_sel
);
    localparam int DLY_LO = BASE_DLY;
    localparam int DLY_HI = BASE_DLY + 2;
    localparam int HIST_W = DLY_HI + 1;

    logic [HIST_W-1:0] hist_q;   // bit k holds de from k ticks back

    // Shift a new display-enable sample in at each cycle start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (tick) begin
            hist_q <= {hist_q[HIST_W-2:0], de};
        end
    end

    // Pick the sample age that the wake-up phase implies.
    always_comb begin
        de_sel = deep_sel ? hist_q[DLY_HI] : hist_q[DLY_LO];
    end
endmodule

// File: rtl/slot_issue.sv
// Registers the slot outcome at each tick: a CPU grant, a video fetch or a
// refresh. It also emits the one-clock load strobe that follows a fetch.
// Assumes next_kind and de_sel are valid at every tick edge.
module slot_issue
    import vdram_arb_pkg::*;
#(
    parameter int STEP_W     = 4,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  slot_kind_e        next_kind,
    input  logic              de_sel,
    input  logic              cpu_req,
    output logic              cpu_grant,
    output logic              vid_grant,
    output logic              ref_req,
    output logic [STEP_W-1:0] addr_step,
    output logic              load_stb
);
    localparam logic [STEP_W-1:0] STEP_VAL = STEP_W'(WORD_BYTES);

    // Decide the slot owner at each cycle start; pulse load after a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpu_grant <= 1'b0;
            vid_grant <= 1'b0;
            ref_req   <= 1'b0;
            load_stb  <= 1'b0;
        end else begin
            load_stb <= tick & vid_grant;
            if (tick) begin
                if (next_kind == SLOT_DISP) begin
                    cpu_grant <= 1'b0;
                    vid_grant <= de_sel;
                    ref_req   <= ~de_sel;
                end else begin
                    cpu_grant <= cpu_req;
                    vid_grant <= 1'b0;
                    ref_req   <= 1'b0;
                end
            end
        end
    end

    // Advance the fetch address by one word during each fetch slot.
    always_comb begin
        addr_step = vid_grant ? STEP_VAL : '0;
    end
endmodule

// File: rtl/vdram_slot_arbiter.sv
// Top of the video DRAM slot arbiter. CPU and display slots alternate, one
// per CPU cycle. Each display slot is a fetch or a refresh, chosen from an
// older display-enable sample. Assumes wake_phase is constant after reset.
module vdram_slot_arbiter #(
    parameter int BASE_DLY   = 1,
    parameter int STEP_W     = 4,
    parameter int WORD_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_8m,
    input  logic              de,
    input  logic [1:0]        wake_phase,
    input  logic              cpu_req,
    output logic              cpu_grant,
    output logic              vid_grant,
    output logic              ref_req,
    output logic [STEP_W-1:0] addr_step,
    output logic              load_stb
);
    import vdram_arb_pkg::*;

    slot_kind_e next_kind;
    logic       de_sel;

    slot_phase_gen i_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_8m),
        .wake_sel (wake_phase[0]),
        .next_kind(next_kind)
    );

    de_sampler #(.BASE_DLY(BASE_DLY)) i_sampler (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_8m),
        .de      (de),
        .deep_sel(wake_phase[1]),
        .de_sel  (de_sel)
    );

    slot_issue #(.STEP_W(STEP_W), .WORD_BYTES(WORD_BYTES)) i_issue (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_8m),
        .next_kind(next_kind),
        .de_sel   (de_sel),
        .cpu_req  (cpu_req),
        .cpu_grant(cpu_grant),
        .vid_grant(vid_grant),
        .ref_req  (ref_req),
        .addr_step(addr_step),
        .load_stb (load_stb)
    );
endmodule

// File: rtl/vdram_slot_arbiter_chk.sv
// Property checker for the video DRAM slot arbiter, attached by bind.
module vdram_slot_arbiter_chk #(
    parameter int STEP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_8m,
    input logic              cpu_grant,
    input logic              vid_grant,
    input logic              ref_req,
    input logic [STEP_W-1:0] addr_step,
    input logic              load_stb
);
    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cpu_grant, vid_grant, ref_req}));

    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> !load_stb);

    // R5
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |-> $past(vid_grant));

    // R2
    disp_then_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_8m && (vid_grant || ref_req)) |=> !(vid_grant || ref_req));

    // R2
    cpu_then_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_8m && cpu_grant) |=> !cpu_grant);

    // R4
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_8m |=> $stable({cpu_grant, vid_grant, ref_req, addr_step}));
endmodule

bind vdram_slot_arbiter vdram_slot_arbiter_chk #(.STEP_W(STEP_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_8m  (tick_8m),
    .cpu_grant(cpu_grant),
    .vid_grant(vid_grant),
    .ref_req  (ref_req),
    .addr_step(addr_step),
    .load_stb (load_stb)
);

// File: tb/test_vdram_slot_arbiter.sv
// Self-checking bench: a vector table of wake phase and display window,
// followed by directed tests for reset, sampling points and CPU slots.
module test_vdram_slot_arbiter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_8m = 1'b0;
    logic       de = 1'b0;
    logic [1:0] wake_phase = 2'd0;
    logic       cpu_req = 1'b0;
    logic       cpu_grant, vid_grant, ref_req, load_stb;
    logic [3:0] addr_step;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Captured per-run statistics.
    int first_load, last_load, loads, late_hi, fetches, bad_step, refs;
    int grants, grants_bad;

    always #10 clk = ~clk;   // 50 MHz

    vdram_slot_arbiter i_vdram_slot_arbiter (
        .clk(clk), .rst_n(rst_n), .tick_8m(tick_8m), .de(de),
        .wake_phase(wake_phase), .cpu_req(cpu_req), .cpu_grant(cpu_grant),
        .vid_grant(vid_grant), .ref_req(ref_req), .addr_step(addr_step),
        .load_stb(load_stb)
    );

    // {wake_phase, de rise cycle, de fall cycle}
    localparam logic [17:0] VEC [7] = '{
        {2'd0, 8'd4,  8'd20},
        {2'd1, 8'd4,  8'd20},
        {2'd2, 8'd4,  8'd20},
        {2'd3, 8'd4,  8'd20},
        {2'd0, 8'd6,  8'd8},
        {2'd3, 8'd10, 8'd40},
        {2'd1, 8'd12, 8'd14}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_stats();
        first_load = -1; last_load = -1; loads = 0; late_hi = 0;
        fetches = 0; bad_step = 0; refs = 0; grants = 0; grants_bad = 0;
    endtask

    // Reset with a chosen wake phase; R1 checks outputs stay quiet.
    task automatic do_reset(input logic [1:0] wp);
        rst_n = 1'b0; tick_8m = 1'b0; de = 1'b0; cpu_req = 1'b0; wake_phase = wp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        clear_stats();
    endtask

    // One CPU cycle n: tick edge then a plain edge; sample mid-cycle.
    task automatic run_cycle(input int n, input logic d, input logic r);
        tick_8m = 1'b1; de = d; cpu_req = r;
        @(negedge clk);
        tick_8m = 1'b0;
        if (load_stb) begin
            if (first_load < 0) first_load = n;
            last_load = n;
            loads++;
        end
        if (vid_grant) begin
            fetches++;
            if (addr_step != 4'd2) bad_step++;
        end else if (addr_step != 4'd0) bad_step++;
        if (ref_req) refs++;
        if (cpu_grant) begin
            grants++;
            if (n[0] == wake_phase[0]) grants_bad++;
        end
        @(negedge clk);
        if (load_stb) late_hi++;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: outputs low in reset and before the first tick
        rst_n = 1'b0; wake_phase = 2'd3;
        repeat (3) @(negedge clk);
        check({cpu_grant, vid_grant, ref_req, load_stb, addr_step} == '0,
              "R1 in reset", int'({cpu_grant, vid_grant, ref_req, load_stb}), 0);
        rst_n = 1'b1; cpu_req = 1'b1; de = 1'b1;
        repeat (2) @(negedge clk);
        check({cpu_grant, vid_grant, ref_req, load_stb, addr_step} == '0,
              "R1 before first tick", int'({cpu_grant, vid_grant, ref_req, load_stb}), 0);

        // Vector table: R6 latency, R7 count and last load, R4, R5, R3
        foreach (VEC[i]) begin
            automatic int wp = int'(VEC[i][17:16]);
            automatic int e  = int'(VEC[i][15:8]);
            automatic int f  = int'(VEC[i][7:0]);
            automatic int nc = f + 10;
            do_reset(VEC[i][17:16]);
            for (int n = 0; n < nc; n++) run_cycle(n, (n >= e) && (n < f), 1'b0);
            check(first_load == e + 3 + wp, "R6 first load cycle", first_load, e + 3 + wp);
            check(loads == (f - e) / 2, "R7 words per line", loads, (f - e) / 2);
            check(last_load == f + 1 + wp, "R7 last load cycle", last_load, f + 1 + wp);
            check(fetches == loads && bad_step == 0, "R4 fetch step", bad_step, 0);
            check(late_hi == 0, "R5 load one clock", late_hi, 0);
            check(refs == nc / 2 - (f - e) / 2, "R3 refresh slots", refs, nc / 2 - (f - e) / 2);
        end

        // R3: de high only at an odd tick is never a decision sample (phase 0)
        do_reset(2'd0);
        for (int n = 0; n < 14; n++) run_cycle(n, n == 5, 1'b0);
        check(loads == 0, "R3 odd-tick de ignored", loads, 0);
        check(refs == 7, "R3 all display slots refresh", refs, 7);

        // R2: constant request, phase 0 -> grants only in odd cycles
        do_reset(2'd0);
        for (int n = 0; n < 8; n++) run_cycle(n, 1'b0, 1'b1);
        check(grants == 4, "R2 grant count phase 0", grants, 4);
        check(grants_bad == 0, "R2 grant in display slot", grants_bad, 0);

        // R2: constant request, phase 1 -> grants only in even cycles
        do_reset(2'd1);
        for (int n = 0; n < 8; n++) run_cycle(n, 1'b0, 1'b1);
        check(grants == 4, "R2 grant count phase 1", grants, 4);
        check(grants_bad == 0, "R2 grant parity phase 1", grants_bad, 0);

        // R2: requests only at display-slot ticks are ignored (phase 0: even)
        do_reset(2'd0);
        for (int n = 0; n < 10; n++) run_cycle(n, 1'b0, n[0] == 1'b0);
        check(grants == 0, "R2 display-slot request ignored", grants, 0);

        // R8: de and requests together; fetch and grant counts both right
        do_reset(2'd2);
        for (int n = 0; n < 30; n++) run_cycle(n, (n >= 4) && (n < 16), 1'b1);
        check(grants == 15 && grants_bad == 0, "R8 cpu slots kept", grants, 15);
        check(fetches == 6, "R8 fetches beside cpu", fetches, 6);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule